// File: doc/BRIEF.md
# Serial Port FIFO Level and Interrupt Unit

This block keeps the occupancy counts for the 16-entry transmit and receive queues of a serial port. It does not hold the queued data and it does not shift bits. The data path reports each push and pop to the block as a one-cycle strobe. Each queue has a control word with an enable, a self-clearing flush command and a trigger level. Firmware can read the three occupancy figures at once in a packed status word: receive level, transmit level and transmit free space.

The block turns those counts into interrupt requests. The receive request arms when the queue is at or above its trigger level. The transmit request arms when the queue has drained to or below its trigger level. An error request collects line-error strobes and receive overruns. The pending bits are sticky and are cleared by writing ones. An enable mask gates the pending bits onto one combined interrupt line. A single write port with a 2-bit select reaches the two control words, the enable mask and the pending-clear register. Each of these is also presented on its own read-back output.

Top module: `uart_fifo_level_irq`

## Requirements
- R1: `fifo_stat` carries the receive level in bits [5:0], the transmit level in bits [13:8] and the transmit free space (16 minus transmit level) in bits [29:24]; every other bit is 0.
- R2: A push raises a level by one and a pop lowers it by one on the next clock edge. A push and a pop in the same cycle leave a partly filled level unchanged. A pop on an empty queue is ignored.
- R3: A push into a full queue (level 16) is dropped. On the receive side, that push drives `rx_overrun` high in the same cycle.
- R4: In the control words (select 0 = transmit, 1 = receive), bit 0 enables the queue, bit 1 is flush and bits [13:8] are the trigger level; the read-back shows enable and trigger. While a queue is disabled, its pushes and pops are ignored.
- R5: A control-word write with bit 1 set zeroes that level at the same clock edge, and it overrides a simultaneous push or pop. Bit 1 always reads back as 0.
- R6: Pending bit 1 (receive) sets one edge after a cycle in which the receive queue is enabled and its level is at or above its trigger.
- R7: Pending bit 0 (transmit) sets one edge after a cycle in which the transmit queue is enabled and its level is at or below its trigger.
- R8: Pending bit 2 (error) sets one edge after a cycle with `err_flag` high or `rx_overrun` high.
- R9: A write to select 3 clears each pending bit written as 1. A set condition present in the same cycle wins, so the bit stays 1.
- R10: `irq` is the OR over bits [2:0] of pending AND enable (select 2). Enable bit 3 (transmit buffer) is stored and read back but has no effect on `irq`.
- R11: `tx_empty` is high exactly when the transmit level is 0.
- R12: After reset, both levels are 0, both control words, the enable mask and the pending bits are 0, `irq` is 0 and `fifo_stat` reads 0x1000_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 tx control, 1 rx control, 2 enable mask, 3 pending clear |
| cfg_wdata | input | 32 | Register write data |
| tx_push | input | 1 | Transmit queue push strobe |
| tx_pop | input | 1 | Transmit queue pop strobe |
| rx_push | input | 1 | Receive queue push strobe |
| rx_pop | input | 1 | Receive queue pop strobe |
| err_flag | input | 1 | Line error strobe (parity or framing) |
| fifo_stat | output | 32 | Packed level and free-space status word |
| tx_cfg_rd | output | 32 | Transmit control read-back |
| rx_cfg_rd | output | 32 | Receive control read-back |
| irq_en_rd | output | 4 | Interrupt enable mask read-back |
| irq_pend | output | 3 | Pending bits: 0 tx, 1 rx, 2 error |
| irq | output | 1 | Combined interrupt request |
| tx_empty | output | 1 | Transmit level is zero |
| rx_overrun | output | 1 | Push into a full receive queue this cycle |

## Verification
The hardest states to reach are the ones where a clear or a push collides with a stronger event in the same cycle. One is a pending-clear write arriving while its trigger condition still holds. Another is a flush write landing in the same cycle as a push. The stimulus reaches them by first driving the levels to exact thresholds with counted push strobes: the receive queue to its trigger and then to 16. It then raises the write strobe and the push strobe on the same negative edge. The overrun pulse is sampled mid-cycle, while the seventeenth receive push is held.

// File: rtl/uart_flv_pkg.sv
`timescale 1ns/1ps
// Package: shared register selects and bit positions for the FIFO level and
// interrupt unit. Assumes a 32-bit configuration data path.
package uart_flv_pkg;
    typedef enum logic [1:0] {
        SEL_TXCTL = 2'd0,
        SEL_RXCTL = 2'd1,
        SEL_IEN   = 2'd2,
        SEL_PEND  = 2'd3
    } cfg_sel_e;

    localparam int CTL_EN_BIT    = 0;
    localparam int CTL_FLUSH_BIT = 1;
    localparam int CTL_TRIG_LSB  = 8;

    localparam int PND_TX  = 0;
    localparam int PND_RX  = 1;
    localparam int PND_ERR = 2;
    localparam int NUM_SRC = 3;
    localparam int IEN_W   = 4;

    localparam int STAT_RX_LSB   = 0;
    localparam int STAT_TX_LSB   = 8;
    localparam int STAT_FREE_LSB = 24;
endpackage

// File: rtl/flv_level_counter.sv
`timescale 1ns/1ps
// Module: occupancy counter for one queue of DEPTH entries.
// Assumes push/pop are one-cycle strobes from the data path. Flush wins over
// push and pop; a disabled counter holds; a push at full is dropped and
// reported on ovf in the same cycle.
module flv_level_counter #(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    output logic [CNT_W-1:0] level,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);

    logic full;
    logic take_push;
    logic take_pop;

    // Purpose: decide which strobes are accepted this cycle.
    always_comb begin
        full      = (level == FULL_C);
        take_push = en && push && !full;
        take_pop  = en && pop && (level != '0);
        ovf       = en && push && full && !flush;
    end

    // Purpose: update the level from flush, push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            level <= '0;
        end else if (take_push && !take_pop) begin
            level <= level + 1'b1;
        end else if (take_pop && !take_push) begin
            level <= level - 1'b1;
        end
    end

    p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL_C);
    p_flush_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0));
    p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !flush && push && !pop && (level == FULL_C)) |=> $stable(level));
    p_disabled_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !flush) |=> $stable(level));
endmodule

// File: rtl/flv_irq_ctrl.sv
`timescale 1ns/1ps
// Module: sticky pending bits with write-1-to-clear, an enable mask and one
// combined request. Assumes set_v are level conditions sampled each cycle;
// a set in the same cycle as a clear keeps the bit at 1. Enable bits above
// NSRC are stored only.
module flv_irq_ctrl #(
    parameter int NSRC  = 3,
    parameter int EN_W  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_we,
    input  logic [EN_W-1:0] en_wdata,
    input  logic            clr_we,
    input  logic [NSRC-1:0] clr_wdata,
    input  logic [NSRC-1:0] set_v,
    output logic [EN_W-1:0] en_q,
    output logic [NSRC-1:0] pend_q,
    output logic            irq
);
    logic [NSRC-1:0] clr_mask;

    // Purpose: form the clear mask for this cycle.
    always_comb clr_mask = clr_we ? clr_wdata : '0;

    // Purpose: hold the enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_we) en_q <= en_wdata;
    end

    // Purpose: one sticky pending bit per source, set wins over clear.
    for (genvar s = 0; s < NSRC; s++) begin : g_src
        always_ff @(posedge clk) begin
            if (!rst_n)        pend_q[s] <= 1'b0;
            else if (set_v[s]) pend_q[s] <= 1'b1;
            else if (clr_mask[s]) pend_q[s] <= 1'b0;
        end

        p_set_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
            set_v[s] |=> pend_q[s]);
        p_w1c_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && clr_wdata[s] && !set_v[s]) |=> !pend_q[s]);
    end

    // Purpose: merge enabled pending bits onto one request line.
    always_comb irq = |(pend_q & en_q[NSRC-1:0]);
endmodule

// File: rtl/uart_fifo_level_irq.sv
`timescale 1ns/1ps
// Module: top of the FIFO level and interrupt unit. Decodes register writes,
// holds both control words, runs one counter per queue, packs the status word
// and feeds threshold and error conditions to the interrupt controller.
// Assumes LVL_W is wide enough to hold DEPTH.
module uart_fifo_level_irq
    import uart_flv_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int LVL_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              tx_push,
    input  logic              tx_pop,
    input  logic              rx_push,
    input  logic              rx_pop,
    input  logic              err_flag,
    output logic [DATA_W-1:0] fifo_stat,
    output logic [DATA_W-1:0] tx_cfg_rd,
    output logic [DATA_W-1:0] rx_cfg_rd,
    output logic [IEN_W-1:0]  irq_en_rd,
    output logic [NUM_SRC-1:0] irq_pend,
    output logic              irq,
    output logic              tx_empty,
    output logic              rx_overrun
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int NCH   = 2;   // channel 0 = transmit, 1 = receive

    logic             wr_tx, wr_rx, wr_ien, wr_pend;
    logic             tx_en_q, rx_en_q;
    logic [LVL_W-1:0] tx_trig_q, rx_trig_q;
    logic [NCH-1:0]   en_v, flush_v, push_v, pop_v, ovf_v;
    logic [CNT_W-1:0] lvl_v [NCH];
    logic [LVL_W-1:0] tx_lvl, rx_lvl, tx_free;
    logic [NUM_SRC-1:0] set_v;
    logic             unused_bits;

    // Purpose: decode the register select.
    always_comb begin
        wr_tx   = cfg_we && (cfg_addr == SEL_TXCTL);
        wr_rx   = cfg_we && (cfg_addr == SEL_RXCTL);
        wr_ien  = cfg_we && (cfg_addr == SEL_IEN);
        wr_pend = cfg_we && (cfg_addr == SEL_PEND);
    end

    // Purpose: hold enable and trigger of both control words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en_q <= 1'b0;  tx_trig_q <= '0;
            rx_en_q <= 1'b0;  rx_trig_q <= '0;
        end else begin
            if (wr_tx) begin
                tx_en_q   <= cfg_wdata[CTL_EN_BIT];
                tx_trig_q <= cfg_wdata[CTL_TRIG_LSB +: LVL_W];
            end
            if (wr_rx) begin
                rx_en_q   <= cfg_wdata[CTL_EN_BIT];
                rx_trig_q <= cfg_wdata[CTL_TRIG_LSB +: LVL_W];
            end
        end
    end

    // Purpose: route per-channel controls into vectors for the counter array.
    always_comb begin
        en_v    = {rx_en_q, tx_en_q};
        flush_v = {wr_rx && cfg_wdata[CTL_FLUSH_BIT], wr_tx && cfg_wdata[CTL_FLUSH_BIT]};
        push_v  = {rx_push, tx_push};
        pop_v   = {rx_pop, tx_pop};
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        flv_level_counter #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en_v[ch]),
            .flush (flush_v[ch]),
            .push  (push_v[ch]),
            .pop   (pop_v[ch]),
            .level (lvl_v[ch]),
            .ovf   (ovf_v[ch])
        );
    end

    // Purpose: widen levels, derive free space and pack the status word.
    always_comb begin
        tx_lvl  = LVL_W'(lvl_v[0]);
        rx_lvl  = LVL_W'(lvl_v[1]);
        tx_free = LVL_W'(DEPTH) - tx_lvl;
        fifo_stat = '0;
        fifo_stat[STAT_RX_LSB   +: LVL_W] = rx_lvl;
        fifo_stat[STAT_TX_LSB   +: LVL_W] = tx_lvl;
        fifo_stat[STAT_FREE_LSB +: LVL_W] = tx_free;
    end

    // Purpose: present control read-back with flush always reading 0.
    always_comb begin
        tx_cfg_rd = '0;
        tx_cfg_rd[CTL_EN_BIT] = tx_en_q;
        tx_cfg_rd[CTL_TRIG_LSB +: LVL_W] = tx_trig_q;
        rx_cfg_rd = '0;
        rx_cfg_rd[CTL_EN_BIT] = rx_en_q;
        rx_cfg_rd[CTL_TRIG_LSB +: LVL_W] = rx_trig_q;
    end

    // Purpose: form interrupt set conditions and side outputs.
    always_comb begin
        rx_overrun      = ovf_v[1];
        tx_empty        = (tx_lvl == '0);
        set_v           = '0;
        set_v[PND_TX]   = tx_en_q && (tx_lvl <= tx_trig_q);
        set_v[PND_RX]   = rx_en_q && (rx_lvl >= rx_trig_q);
        set_v[PND_ERR]  = err_flag || ovf_v[1];
    end

    flv_irq_ctrl #(.NSRC(NUM_SRC), .EN_W(IEN_W)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_we     (wr_ien),
        .en_wdata  (cfg_wdata[IEN_W-1:0]),
        .clr_we    (wr_pend),
        .clr_wdata (cfg_wdata[NUM_SRC-1:0]),
        .set_v     (set_v),
        .en_q      (irq_en_rd),
        .pend_q    (irq_pend),
        .irq       (irq)
    );

    assign unused_bits = ^{cfg_wdata[DATA_W-1:CTL_TRIG_LSB+LVL_W],
                           cfg_wdata[CTL_TRIG_LSB-1:IEN_W], ovf_v[0]};

    p_free_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_stat[STAT_TX_LSB +: LVL_W] + fifo_stat[STAT_FREE_LSB +: LVL_W]) == LVL_W'(DEPTH));
    p_overrun_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |=> irq_pend[PND_ERR]);
    p_empty_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> (fifo_stat[STAT_FREE_LSB +: LVL_W] == LVL_W'(DEPTH)));
endmodule

// File: tb/sim_uart_fifo_level_irq.sv
`timescale 1ns/1ps
module sim_uart_fifo_level_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic        tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic        err_flag = 1'b0;
    logic [31:0] fifo_stat, tx_cfg_rd, rx_cfg_rd;
    logic [3:0]  irq_en_rd;
    logic [2:0]  irq_pend;
    logic        irq, tx_empty, rx_overrun;
    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    uart_fifo_level_irq u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .tx_push(tx_push), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_pop(rx_pop), .err_flag(err_flag),
        .fifo_stat(fifo_stat), .tx_cfg_rd(tx_cfg_rd), .rx_cfg_rd(rx_cfg_rd),
        .irq_en_rd(irq_en_rd), .irq_pend(irq_pend), .irq(irq),
        .tx_empty(tx_empty), .rx_overrun(rx_overrun)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0; cfg_wdata = 32'd0;
    endtask

    task automatic push_tx(input int n);
        @(negedge clk); tx_push = 1'b1;
        repeat (n - 1) @(negedge clk);
        @(negedge clk); tx_push = 1'b0;
    endtask

    task automatic pop_tx(input int n);
        @(negedge clk); tx_pop = 1'b1;
        repeat (n - 1) @(negedge clk);
        @(negedge clk); tx_pop = 1'b0;
    endtask

    task automatic push_rx(input int n);
        @(negedge clk); rx_push = 1'b1;
        repeat (n - 1) @(negedge clk);
        @(negedge clk); rx_push = 1'b0;
    endtask

    task automatic t_reset;
        check("R12 status", fifo_stat, 32'h1000_0000);
        check("R12 tx cfg", tx_cfg_rd, 32'd0);
        check("R12 rx cfg", rx_cfg_rd, 32'd0);
        check("R12 pending/irq", {27'd0, irq_en_rd, irq_pend, irq}, 32'd0);
        check("R11 empty at reset", {31'd0, tx_empty}, 32'd1);
    endtask

    task automatic t_enable;
        wr(2'd0, 32'h0000_0001);
        check("R7 tx pending not yet", {29'd0, irq_pend}, 32'd0);
        wr(2'd1, 32'h0000_0401);
        check("R4 tx readback", tx_cfg_rd, 32'h0000_0001);
        check("R4 rx readback", rx_cfg_rd, 32'h0000_0401);
        check("R7 tx pending set at level 0", {31'd0, irq_pend[0]}, 32'd1);
    endtask

    task automatic t_tx_levels;
        push_tx(3);
        check("R1 status tx 3", fifo_stat, 32'h0D00_0300);
        check("R11 not empty", {31'd0, tx_empty}, 32'd0);
        wr(2'd3, 32'h1);
        check("R9 w1c clears tx pending", {31'd0, irq_pend[0]}, 32'd0);
        @(negedge clk); tx_push = 1'b1; tx_pop = 1'b1;
        @(negedge clk); tx_push = 1'b0; tx_pop = 1'b0;
        check("R2 push+pop holds", fifo_stat, 32'h0D00_0300);
        pop_tx(3);
        check("R11 empty after pops", {31'd0, tx_empty}, 32'd1);
        check("R7 pending one edge later", {31'd0, irq_pend[0]}, 32'd0);
        @(negedge clk);
        check("R7 tx pending set", {31'd0, irq_pend[0]}, 32'd1);
        pop_tx(1);
        check("R2 pop on empty ignored", fifo_stat, 32'h1000_0000);
    endtask

    task automatic t_rx_trigger;
        push_rx(3);
        check("R6 below trigger", {31'd0, irq_pend[1]}, 32'd0);
        push_rx(1);
        check("R1 status rx 4", fifo_stat, 32'h1000_0004);
        check("R6 not yet", {31'd0, irq_pend[1]}, 32'd0);
        @(negedge clk);
        check("R6 rx pending set", {31'd0, irq_pend[1]}, 32'd1);
        wr(2'd3, 32'h2);
        check("R9 set wins over clear", {31'd0, irq_pend[1]}, 32'd1);
    endtask

    task automatic t_irq_mask;
        wr(2'd2, 32'h8);
        check("R10 enable readback", {28'd0, irq_en_rd}, 32'h8);
        check("R10 buffer bit no irq", {31'd0, irq}, 32'd0);
        wr(2'd2, 32'h2);
        check("R10 rx enabled irq", {31'd0, irq}, 32'd1);
        wr(2'd2, 32'h0);
        check("R10 masked irq", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_overrun;
        push_rx(12);
        check("R1 status rx 16", fifo_stat, 32'h1000_0010);
        @(negedge clk); rx_push = 1'b1;
        #1;
        check("R3 overrun pulse", {31'd0, rx_overrun}, 32'd1);
        @(negedge clk); rx_push = 1'b0;
        #1;
        check("R3 rx push dropped", fifo_stat, 32'h1000_0010);
        check("R8 overrun sets error", {31'd0, irq_pend[2]}, 32'd1);
        push_tx(17);
        check("R3 tx full drop", fifo_stat, 32'h0000_1010);
        wr(2'd0, 32'h0000_0003);
        check("R5 tx flush", fifo_stat, 32'h1000_0010);
        check("R5 flush reads 0", tx_cfg_rd, 32'h0000_0001);
    endtask

    task automatic t_flush_disable;
        @(negedge clk); cfg_we = 1'b1; cfg_addr = 2'd1; cfg_wdata = 32'h0000_0403; rx_push = 1'b1;
        @(negedge clk); cfg_we = 1'b0; cfg_wdata = 32'd0; rx_push = 1'b0;
        check("R5 flush beats push", fifo_stat, 32'h1000_0000);
        check("R5 rx readback", rx_cfg_rd, 32'h0000_0401);
        wr(2'd1, 32'h0);
        push_rx(2);
        check("R4 disabled ignores push", fifo_stat, 32'h1000_0000);
        wr(2'd3, 32'h4);
        check("R9 error cleared", {31'd0, irq_pend[2]}, 32'd0);
        @(negedge clk); err_flag = 1'b1;
        @(negedge clk); err_flag = 1'b0;
        check("R8 err_flag sets error", {31'd0, irq_pend[2]}, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_tx_levels();
        t_rx_trigger();
        t_irq_mask();
        t_overrun();
        t_flush_disable();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule